// File: doc/BRIEF.md
# Four-Register Datapath with Opcode Decoder

This block is a small 4-bit execution datapath that carries out one instruction on every rising clock edge. Each instruction is a 3-bit opcode and two 2-bit register selectors: a destination selector and a source selector. Inside are four 4-bit registers, a combinational decoder, an arithmetic unit and a write-data selector. The decoder turns the opcode into read addresses, a write address, a write enable and a choice of write data. The write data is either the external data input or the arithmetic result.

A sequencer outside the block drives the instruction fields every cycle. It reads two things back: the data output, which shows the arithmetic result in the current cycle, and a zero flag. A store instruction uses the data output to expose a register. A counted loop uses the zero flag to detect when a decrement reaches zero. A copy reads its source register through the first arithmetic port, so that port serves as the data path for every single-operand instruction.

Top module: `rf_datapath`

## Requirements
- R1: A synchronous active-high reset clears all four registers to 0. After reset, a store of any register outputs 0.
- R2: Opcode 001 (set) writes the value 1 into the register selected by the destination field.
- R3: Opcode 010 (increment) writes the destination register plus one, modulo 16, so 15 becomes 0.
- R4: Opcode 011 (decrement) writes the destination register minus one, modulo 16, so 0 becomes 15.
- R5: Opcode 100 (load) writes the 4-bit data input into the destination register.
- R6: Opcode 101 (store) drives the destination register's value on the data output in the same cycle and writes no register.
- R7: Opcode 110 (add) writes the sum of the destination and source registers, modulo 16, into the destination register.
- R8: Opcode 111 (copy) writes the source register's value into the destination register and leaves the source register unchanged.
- R9: Opcode 000 (noop) writes no register and drives 0 on the data output.
- R10: In every cycle the zero flag is 1 exactly when the data output is 0000.
- R11: For opcodes 001 through 101, the source field has no effect on the result or on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 3 | Instruction opcode |
| opr_dst | input | 2 | Destination register selector |
| opr_src | input | 2 | Source register selector |
| mem_in | input | 4 | External data written by the load instruction |
| mem_out | output | 4 | Arithmetic result of the current cycle |
| zero_flag | output | 1 | High when mem_out is zero |

## Verification
The assertions check several things on every cycle. The flag must match the output. Store must show the destination register. Idle cycles must leave all registers frozen. The register written by a set, load, increment, decrement or copy must hold the expected value on the following edge. Other behaviour only shows up across a whole instruction sequence, so the directed scenarios cover it. That includes the modulo-16 wraps at the ends of the range and the source field being ignored by single-operand opcodes. The scenarios also run a complete counted loop that computes Fibonacci numbers and ends on the zero flag.

// File: rtl/rfdp_pkg.sv
package rfdp_pkg;

    localparam int DATA_W = 4;
    localparam int REG_N  = 4;
    localparam int ADDR_W = $clog2(REG_N);
    localparam int OP_W   = 3;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 3'd0,
        OP_SET   = 3'd1,
        OP_INC   = 3'd2,
        OP_DEC   = 3'd3,
        OP_LOAD  = 3'd4,
        OP_STORE = 3'd5,
        OP_ADD   = 3'd6,
        OP_COPY  = 3'd7
    } op_e;

    typedef struct packed {
        op_e   alu_op;
        addr_t rd_a;
        addr_t rd_b;
        addr_t wr_addr;
        logic  wr_en;
        logic  take_mem;
    } ctrl_t;

    function automatic logic op_writes(op_e op);
        return !(op == OP_NOP || op == OP_STORE);
    endfunction

    function automatic word_t pick_word(logic [REG_N*DATA_W-1:0] flat, addr_t idx);
        return flat[idx*DATA_W +: DATA_W];
    endfunction

endpackage

// File: rtl/rfdp_decode.sv
module rfdp_decode
    import rfdp_pkg::*;
(
    input  op_e   op,
    input  addr_t dst,
    input  addr_t src,
    output ctrl_t ctrl
);
    always_comb begin
        ctrl.alu_op   = op;
        ctrl.rd_b     = src;
        ctrl.rd_a     = (op == OP_COPY) ? src : dst;
        ctrl.wr_addr  = dst;
        ctrl.wr_en    = op_writes(op);
        ctrl.take_mem = (op == OP_LOAD);
    end
endmodule

// File: rtl/rfdp_alu.sv
module rfdp_alu
    import rfdp_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  op_e          op,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic         is_zero
);
    logic [W-1:0] addend;
    logic         carry_in;
    logic [W-1:0] carry;
    logic [W-1:0] sum;

    always_comb begin
        addend   = '0;
        carry_in = 1'b0;
        unique case (op)
            OP_INC:  carry_in = 1'b1;
            OP_DEC:  addend   = '1;
            OP_ADD:  addend   = opnd_b;
            default: ;
        endcase
    end

    assign carry[0] = carry_in;

    for (genvar i = 0; i < W; i++) begin : g_ripple
        assign sum[i] = opnd_a[i] ^ addend[i] ^ carry[i];
        if (i < W - 1) begin : g_carry
            assign carry[i+1] = (opnd_a[i] & addend[i]) |
                                (opnd_a[i] & carry[i])  |
                                (addend[i] & carry[i]);
        end
    end

    always_comb begin
        unique case (op)
            OP_NOP:                      result = '0;
            OP_SET:                      result = W'(1);
            OP_INC, OP_DEC, OP_ADD:      result = sum;
            OP_LOAD, OP_STORE, OP_COPY:  result = opnd_a;
            default:                     result = '0;
        endcase
    end

    assign is_zero = ~|result;
endmodule

// File: rtl/rfdp_regfile.sv
module rfdp_regfile
    import rfdp_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = REG_N,
    localparam int AW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [W-1:0]    wr_data,
    input  logic [AW-1:0]   rd_a,
    input  logic [AW-1:0]   rd_b,
    output logic [W-1:0]    rd_a_data,
    output logic [W-1:0]    rd_b_data,
    output logic [N*W-1:0]  snapshot
);
    logic [W-1:0] mem [N];
    logic [N-1:0] wsel;

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign wsel[g] = wr_en && (wr_addr == AW'(g));
        assign snapshot[g*W +: W] = mem[g];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst)          mem[i] <= '0;
            else if (wsel[i]) mem[i] <= wr_data;
        end
    end

    assign rd_a_data = mem[rd_a];
    assign rd_b_data = mem[rd_b];

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(snapshot)); // R9
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
    import rfdp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  opcode,
    input  logic [ADDR_W-1:0] opr_dst,
    input  logic [ADDR_W-1:0] opr_src,
    input  logic [DATA_W-1:0] mem_in,
    output logic [DATA_W-1:0] mem_out,
    output logic             zero_flag
);
    ctrl_t ctrl;
    op_e   op;
    word_t port_a, port_b, alu_res, wr_data;
    logic [REG_N*DATA_W-1:0] snap;

    assign op = op_e'(opcode);

    rfdp_decode u_dec (
        .op   (op),
        .dst  (opr_dst),
        .src  (opr_src),
        .ctrl (ctrl)
    );

    rfdp_regfile #(.W(DATA_W), .N(REG_N)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (ctrl.wr_en),
        .wr_addr   (ctrl.wr_addr),
        .wr_data   (wr_data),
        .rd_a      (ctrl.rd_a),
        .rd_b      (ctrl.rd_b),
        .rd_a_data (port_a),
        .rd_b_data (port_b),
        .snapshot  (snap)
    );

    rfdp_alu #(.W(DATA_W)) u_alu (
        .op      (ctrl.alu_op),
        .opnd_a  (port_a),
        .opnd_b  (port_b),
        .result  (alu_res),
        .is_zero (zero_flag)
    );

    assign wr_data = ctrl.take_mem ? mem_in : alu_res;
    assign mem_out = alu_res;

    // Assertion support: remember last instruction and operand values
    logic  v_q;
    op_e   op_q;
    addr_t dst_q;
    word_t mem_in_q, dst_val_q, src_val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q       <= 1'b0;
            op_q      <= OP_NOP;
            dst_q     <= '0;
            mem_in_q  <= '0;
            dst_val_q <= '0;
            src_val_q <= '0;
        end else begin
            v_q       <= 1'b1;
            op_q      <= op;
            dst_q     <= opr_dst;
            mem_in_q  <= mem_in;
            dst_val_q <= pick_word(snap, opr_dst);
            src_val_q <= pick_word(snap, opr_src);
        end
    end

    AST_SET_ONE: assert property (@(posedge clk) disable iff (rst)
        (v_q && op_q == OP_SET) |-> pick_word(snap, dst_q) == word_t'(1)); // R2
    AST_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (v_q && op_q == OP_INC) |-> pick_word(snap, dst_q) == word_t'(dst_val_q + 1'b1)); // R3
    AST_DEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (v_q && op_q == OP_DEC) |-> pick_word(snap, dst_q) == word_t'(dst_val_q - 1'b1)); // R4
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        (v_q && op_q == OP_LOAD) |-> pick_word(snap, dst_q) == mem_in_q); // R5
    AST_STORE_SHOWS: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STORE) |-> mem_out == pick_word(snap, opr_dst)); // R6
    AST_COPY_MOVES: assert property (@(posedge clk) disable iff (rst)
        (v_q && op_q == OP_COPY) |-> pick_word(snap, dst_q) == src_val_q); // R8
    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
        zero_flag == (mem_out == '0)); // R10
endmodule

// File: tb/rf_datapath_bench.sv
`timescale 1ns/1ps
module rf_datapath_bench;
    import rfdp_pkg::*;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] opcode;
    logic [1:0] opr_dst, opr_src;
    logic [3:0] mem_in;
    logic [3:0] mem_out;
    logic       zero_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rf_datapath u_rf_datapath (
        .clk(clk), .rst(rst), .opcode(opcode), .opr_dst(opr_dst),
        .opr_src(opr_src), .mem_in(mem_in), .mem_out(mem_out),
        .zero_flag(zero_flag)
    );

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one instruction after a falling edge, sample combinational outputs,
    // then let the rising edge commit it.
    task automatic run(input op_e op, input logic [1:0] d, input logic [1:0] s,
                       input logic [3:0] mi, output logic [3:0] mo, output logic zf);
        @(negedge clk);
        opcode = op; opr_dst = d; opr_src = s; mem_in = mi;
        #1;
        mo = mem_out; zf = zero_flag;
        @(posedge clk);
    endtask

    task automatic peek(string req, logic [1:0] r, logic [3:0] exp);
        logic [3:0] mo; logic zf;
        run(OP_STORE, r, 2'(r + 1), 4'hA, mo, zf);
        check(req, mo, exp);
        check("R10", {3'b0, zf}, {3'b0, exp == 4'd0});
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1; opcode = OP_NOP; opr_dst = 0; opr_src = 0; mem_in = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        for (int r = 0; r < 4; r++) peek("R1", 2'(r), 4'd0);
    endtask

    task automatic t_set_load;
        logic [3:0] mo; logic zf;
        run(OP_SET, 2'd1, 2'd3, 4'd9, mo, zf);
        peek("R2", 2'd1, 4'd1);
        run(OP_LOAD, 2'd2, 2'd0, 4'd11, mo, zf);
        peek("R5", 2'd2, 4'd11);
        peek("R11", 2'd1, 4'd1);
    endtask

    task automatic t_inc_dec;
        logic [3:0] mo; logic zf;
        run(OP_LOAD, 2'd2, 2'd0, 4'd15, mo, zf);
        run(OP_INC, 2'd2, 2'd1, 4'd7, mo, zf);
        check("R10", {3'b0, zf}, 4'd1);
        peek("R3", 2'd2, 4'd0);
        run(OP_INC, 2'd2, 2'd3, 4'd0, mo, zf);
        peek("R11", 2'd2, 4'd1);
        run(OP_LOAD, 2'd3, 2'd0, 4'd0, mo, zf);
        run(OP_DEC, 2'd3, 2'd2, 4'd5, mo, zf);
        check("R4", mo, 4'd15);
        peek("R4", 2'd3, 4'd15);
    endtask

    task automatic t_add;
        logic [3:0] mo; logic zf;
        run(OP_LOAD, 2'd0, 2'd0, 4'd7, mo, zf);
        run(OP_LOAD, 2'd1, 2'd0, 4'd5, mo, zf);
        run(OP_ADD, 2'd1, 2'd0, 4'd0, mo, zf);
        peek("R7", 2'd1, 4'd12);
        peek("R7", 2'd0, 4'd7);
        run(OP_ADD, 2'd1, 2'd1, 4'd0, mo, zf);
        peek("R7", 2'd1, 4'd8);
    endtask

    task automatic t_copy;
        logic [3:0] mo; logic zf;
        run(OP_LOAD, 2'd2, 2'd0, 4'd9, mo, zf);
        run(OP_COPY, 2'd3, 2'd2, 4'd4, mo, zf);
        check("R8", mo, 4'd9);
        peek("R8", 2'd3, 4'd9);
        peek("R8", 2'd2, 4'd9);
    endtask

    task automatic t_store_noop;
        logic [3:0] mo; logic zf;
        run(OP_LOAD, 2'd0, 2'd0, 4'd6, mo, zf);
        run(OP_STORE, 2'd0, 2'd1, 4'd13, mo, zf);
        check("R6", mo, 4'd6);
        run(OP_NOP, 2'd0, 2'd0, 4'd14, mo, zf);
        check("R9", mo, 4'd0);
        check("R10", {3'b0, zf}, 4'd1);
        peek("R6", 2'd0, 4'd6);
        peek("R9", 2'd3, 4'd9);
    endtask

    task automatic t_fib(int n);
        logic [3:0] mo; logic zf;
        int a = 1, b = 1, t, iter = 0;
        for (int k = 0; k < n; k++) begin t = a; a = a + b; b = t; end
        run(OP_LOAD, 2'd0, 2'd0, 4'(n), mo, zf);
        run(OP_SET, 2'd1, 2'd0, 4'd0, mo, zf);
        run(OP_SET, 2'd2, 2'd0, 4'd0, mo, zf);
        run(OP_STORE, 2'd0, 2'd0, 4'd0, mo, zf);
        check("R10", {3'b0, zf}, {3'b0, n == 0});
        while (!zf && iter < 16) begin
            run(OP_COPY, 2'd3, 2'd1, 4'd0, mo, zf);
            run(OP_ADD, 2'd1, 2'd2, 4'd0, mo, zf);
            run(OP_COPY, 2'd2, 2'd3, 4'd0, mo, zf);
            run(OP_DEC, 2'd0, 2'd0, 4'd0, mo, zf);
            iter++;
        end
        check("R10", 4'(iter), 4'(n));
        peek("R7", 2'd1, 4'(a));
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; opcode = 0; opr_dst = 0; opr_src = 0; mem_in = 0;
        t_reset();
        t_set_load();
        t_inc_dec();
        t_add();
        t_copy();
        t_store_noop();
        t_fib(5);
        t_fib(1);
        t_fib(0);
        finish_run();
    end
endmodule